// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table kept in main memory. It takes a 32-bit virtual address with 4 KB pages. The top ten address bits index a directory page that the per-process root pointer locates. The directory entry names a second-level page, and the next ten bits index into that page to fetch the leaf entry. The leaf supplies the physical frame number and a writable permission bit. The low twelve bits pass through unchanged as the page offset.

The requester presents one virtual address and a read/write flag when the walker is idle. The walker then issues at most two word reads over a memory port that allows one read in flight at a time. It returns a single-cycle response carrying a status code, the frame number, the writable bit and the full physical address. A table-length register bounds the top-level index: an index at or beyond it faults at once, without touching memory. An entry whose valid bit is clear faults at whichever level it is found. A write that reaches a leaf without write permission gets its own protection status, so that a fault handler can tell it apart from a missing page.

Top module: `pw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_valid` is 0. The root pointer and the table length reset to 0, so every request faults with the range status until the configuration is loaded.
- R2: On a successful walk, `rsp_pa[11:0]` equals the request's `va[11:0]` and `rsp_pa[31:12]` equals `rsp_pfn`.
- R3: The first memory read goes to root + va[31:22]*4. The second goes to (directory entry bits 31:12, shifted left by 12) + va[21:12]*4.
- R4: If va[31:22] is greater than or equal to the table length, the response has status 1 (range fault) and no memory read is issued.
- R5: A directory entry with bit 0 (valid) clear ends the walk after exactly one read, with status 2 (not present).
- R6: A leaf entry with bit 0 clear ends the walk after exactly two reads, with status 2 (not present).
- R7: A write request to a valid leaf whose bit 1 (writable) is clear returns status 3 (protection). A read request to the same leaf succeeds, and so does a write request to a leaf with bit 1 set.
- R8: On success the status is 0, `rsp_pfn` is leaf bits 31:12 and `rsp_writable` is leaf bit 1. On any fault, `rsp_pfn`, `rsp_writable` and `rsp_pa` are 0.
- R9: A request is accepted only while `req_ready` is high. `req_ready` drops in the cycle after acceptance and returns only after the response. `rsp_valid` is high for exactly one cycle per request.
- R10: A `cfg_load` pulse loads the root pointer and the table length. A request accepted after that edge uses the new values. A request accepted in the same cycle uses the old values.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high in the next cycle and `mem_addr` stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load root pointer and table length |
| cfg_root | input | 32 | Physical address of the directory page |
| cfg_len | input | 11 | Number of usable directory entries (0 to 1024) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 range fault, 2 not present, 3 protection |
| rsp_pfn | output | 20 | Physical frame number |
| rsp_writable | output | 1 | Leaf writable permission |
| rsp_pa | output | 32 | Translated physical address |
| mem_addr | output | 32 | Table entry read address |
| mem_valid | output | 1 | Read request to memory |
| mem_ready | input | 1 | Memory accepts the read |
| mem_rdata | input | 32 | Returned table entry |
| mem_rvalid | input | 1 | Read data valid |

## Verification
The bench builds the walker with its default parameters: 32-bit virtual and physical addresses, 10-bit indexes and a 12-bit offset. With these values the full directory range is reachable, including a table length of 1024 and the top index 1023. The memory model is a 16 KB array that holds two alternative directory pages and two leaf pages. This lets a root change redirect every walk, and lets the length boundary be probed at index len-1 and at index len. Random ready stalls and read latencies of 0 to 2 cycles exercise the hold rule on the memory port.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int LEVELS    = 2;
  localparam int VALID_BIT = 0;
  localparam int WRITE_BIT = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_WT_DIR, S_RD_LEAF, S_WT_LEAF, S_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    ST_OK = 2'd0, ST_RANGE = 2'd1, ST_ABSENT = 2'd2, ST_PROT = 2'd3
  } walk_status_e;
endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
  parameter int PA_W  = 32,
  parameter int IDX_W = 10
) (
  input  logic [PA_W-1:0]  base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  addr
);
  localparam int PAD_W = PA_W - IDX_W - 2;
  // each entry is one 32-bit word
  assign addr = base + {{PAD_W{1'b0}}, idx, 2'b00};
endmodule

// File: rtl/pw_entry_check.sv
module pw_entry_check
  import pw_pkg::*;
(
  input  logic         ent_valid,
  input  logic         ent_writable,
  input  logic         is_leaf,
  input  logic         want_write,
  output walk_status_e verdict
);
  always_comb begin
    if (!ent_valid)                               verdict = ST_ABSENT;
    else if (is_leaf && want_write && !ent_writable) verdict = ST_PROT;
    else                                          verdict = ST_OK;
  end
endmodule

// File: rtl/pw_walker.sv
module pw_walker
  import pw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_load,
  input  logic [PA_W-1:0]         cfg_root,
  input  logic [IDX_W:0]          cfg_len,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_va,
  input  logic                    req_write,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_status,
  output logic [PA_W-OFF_W-1:0]   rsp_pfn,
  output logic                    rsp_writable,
  output logic [PA_W-1:0]         rsp_pa,
  output logic [PA_W-1:0]         mem_addr,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  input  logic [PA_W-1:0]         mem_rdata,
  input  logic                    mem_rvalid
);
  localparam int PFN_W = PA_W - OFF_W;
  localparam int LEN_W = IDX_W + 1;
  localparam int LOW_W = VA_W - IDX_W;

  walk_state_e       state_q;
  walk_status_e      status_q, verdict;
  logic [PA_W-1:0]   root_q, addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [LOW_W-1:0]  va_lo_q;
  logic              wr_q;
  logic [PFN_W-1:0]  pfn_q;
  logic              wbl_q;
  logic [PA_W-1:0]   pa_q;
  logic [IDX_W-1:0]  top_idx;
  logic [PFN_W-1:0]  ent_frame;
  logic              unused_ent_bits;

  assign top_idx         = req_va[VA_W-1 -: IDX_W];
  assign ent_frame       = mem_rdata[PA_W-1:OFF_W];
  assign unused_ent_bits = ^mem_rdata[OFF_W-1:2];

  // per-level entry address generators
  logic [PA_W-1:0]  lvl_base [LEVELS];
  logic [IDX_W-1:0] lvl_idx  [LEVELS];
  logic [PA_W-1:0]  lvl_addr [LEVELS];

  assign lvl_base[0] = root_q;
  assign lvl_idx[0]  = top_idx;
  assign lvl_base[1] = {ent_frame, {OFF_W{1'b0}}};
  assign lvl_idx[1]  = va_lo_q[OFF_W +: IDX_W];

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    pw_entry_addr #(.PA_W(PA_W), .IDX_W(IDX_W)) u_addr (
      .base(lvl_base[g]), .idx(lvl_idx[g]), .addr(lvl_addr[g])
    );
  end

  pw_entry_check u_check (
    .ent_valid   (mem_rdata[VALID_BIT]),
    .ent_writable(mem_rdata[WRITE_BIT]),
    .is_leaf     (state_q == S_WT_LEAF),
    .want_write  (wr_q),
    .verdict     (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      status_q <= ST_OK;
      root_q   <= '0;
      len_q    <= '0;
      addr_q   <= '0;
      va_lo_q  <= '0;
      wr_q     <= 1'b0;
      pfn_q    <= '0;
      wbl_q    <= 1'b0;
      pa_q     <= '0;
    end else begin
      if (cfg_load) begin
        root_q <= cfg_root;
        len_q  <= cfg_len;
      end
      case (state_q)
        S_IDLE: if (req_valid) begin
          va_lo_q  <= req_va[LOW_W-1:0];
          wr_q     <= req_write;
          status_q <= ST_OK;
          pfn_q    <= '0;
          wbl_q    <= 1'b0;
          pa_q     <= '0;
          if ({1'b0, top_idx} >= len_q) begin
            status_q <= ST_RANGE;
            state_q  <= S_DONE;
          end else begin
            addr_q  <= lvl_addr[0];
            state_q <= S_RD_DIR;
          end
        end
        S_RD_DIR:  if (mem_ready) state_q <= S_WT_DIR;
        S_WT_DIR:  if (mem_rvalid) begin
          if (verdict != ST_OK) begin
            status_q <= verdict;
            state_q  <= S_DONE;
          end else begin
            addr_q  <= lvl_addr[1];
            state_q <= S_RD_LEAF;
          end
        end
        S_RD_LEAF: if (mem_ready) state_q <= S_WT_LEAF;
        S_WT_LEAF: if (mem_rvalid) begin
          status_q <= verdict;
          if (verdict == ST_OK) begin
            pfn_q <= ent_frame;
            wbl_q <= mem_rdata[WRITE_BIT];
            pa_q  <= {ent_frame, va_lo_q[OFF_W-1:0]};
          end
          state_q <= S_DONE;
        end
        default:   state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == S_IDLE);
  assign rsp_valid    = (state_q == S_DONE);
  assign mem_valid    = (state_q == S_RD_DIR) || (state_q == S_RD_LEAF);
  assign mem_addr     = addr_q;
  assign rsp_status   = status_q;
  assign rsp_pfn      = pfn_q;
  assign rsp_writable = wbl_q;
  assign rsp_pa       = pa_q;

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);
  // R4
  range_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && ({1'b0, req_va[VA_W-1 -: IDX_W]} >= len_q)
    |=> rsp_valid && rsp_status == ST_RANGE && !mem_valid);
  // R8
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_status != ST_OK |-> rsp_pfn == '0 && !rsp_writable && rsp_pa == '0);
  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_status == ST_OK
    |-> rsp_pa[OFF_W-1:0] == va_lo_q[OFF_W-1:0] && rsp_pa[PA_W-1:OFF_W] == rsp_pfn);
endmodule

// File: tb/test_pw_walker.sv
`timescale 1ns/1ps
module test_pw_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_root = '0;
  logic [10:0] cfg_len = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready, rsp_valid, rsp_writable, mem_valid;
  logic [1:0]  rsp_status;
  logic [19:0] rsp_pfn;
  logic [31:0] rsp_pa, mem_addr;
  logic        mem_ready, mem_rvalid;
  logic [31:0] mem_rdata;

  always #2.5 clk = ~clk;

  pw_walker i_pw_walker (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_root(cfg_root), .cfg_len(cfg_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_pfn(rsp_pfn),
    .rsp_writable(rsp_writable), .rsp_pa(rsp_pa), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid)
  );

  // memory model: 4 pages of 1024 words
  logic [31:0] mem_w [0:4095];
  logic [31:0] rd_log [0:15];
  int          rd_total, hold_err, nchk, nbad;
  logic        busy, pend;
  logic [1:0]  dly;
  logic [31:0] ba, pend_addr;
  logic [31:0] root_cur;
  logic [10:0] len_cur;
  bit          finished;

  always @(posedge clk) begin
    if (rst) begin
      mem_ready <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0;
      busy <= 1'b0; pend <= 1'b0; rd_total <= 0; dly <= '0;
    end else begin
      if (pend && !(mem_valid && mem_addr == pend_addr)) hold_err <= hold_err + 1;
      pend      <= mem_valid && !mem_ready;
      pend_addr <= mem_addr;
      mem_ready <= ($urandom % 3) != 0;
      mem_rvalid <= 1'b0;
      if (busy) begin
        if (dly == 0) begin
          mem_rvalid <= 1'b1; mem_rdata <= mem_w[ba[13:2]]; busy <= 1'b0;
        end else dly <= dly - 1;
      end
      if (mem_valid && mem_ready) begin
        busy <= 1'b1; ba <= mem_addr; dly <= 2'($urandom % 3);
        rd_log[rd_total % 16] <= mem_addr;
        rd_total <= rd_total + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // reference model from the requirements
  task automatic model(input logic [31:0] va, input bit wr,
                       output logic [1:0] st, output logic [19:0] pfn, output bit w,
                       output logic [31:0] pa, output int nrd,
                       output logic [31:0] a1, output logic [31:0] a2);
    logic [31:0] e1, e2;
    st = 2'd0; pfn = '0; w = 1'b0; pa = '0; nrd = 0; a1 = '0; a2 = '0;
    if ({1'b0, va[31:22]} >= len_cur) begin st = 2'd1; return; end
    a1 = root_cur + {20'd0, va[31:22], 2'b00};
    e1 = mem_w[a1[13:2]]; nrd = 1;
    if (!e1[0]) begin st = 2'd2; return; end
    a2 = {e1[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
    e2 = mem_w[a2[13:2]]; nrd = 2;
    if (!e2[0]) st = 2'd2;
    else if (wr && !e2[1]) st = 2'd3;
    else begin pfn = e2[31:12]; w = e2[1]; pa = {e2[31:12], va[11:0]}; end
  endtask

  task automatic load_cfg(input logic [31:0] root, input logic [10:0] len);
    @(negedge clk);
    cfg_load = 1'b1; cfg_root = root; cfg_len = len;
    @(negedge clk);
    cfg_load = 1'b0;
    root_cur = root; len_cur = len;
  endtask

  task automatic run_req(input logic [31:0] va, input bit wr, input string tag);
    logic [1:0] est; logic [19:0] epfn; bit ew; logic [31:0] epa, ea1, ea2;
    int enrd, start, waitc;
    model(va, wr, est, epfn, ew, epa, enrd, ea1, ea2);
    @(negedge clk);
    req_va = va; req_write = wr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    start = rd_total;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, {tag, " R9 ready low after accept"}, {31'd0, req_ready}, 32'd0);
    waitc = 0;
    while (!rsp_valid && waitc < 200) begin @(negedge clk); waitc++; end
    chk(rsp_valid, {tag, " R9 response arrives"}, {31'd0, rsp_valid}, 32'd1);
    chk(rsp_status == est, {tag, " R4/R5/R6/R7 status"}, {30'd0, rsp_status}, {30'd0, est});
    chk(rsp_pfn == epfn && rsp_writable == ew, {tag, " R8 frame and permission"},
        {rsp_pfn, 11'd0, rsp_writable}, {epfn, 11'd0, ew});
    chk(rsp_pa == epa, {tag, " R2 physical address"}, rsp_pa, epa);
    chk(rd_total - start == enrd, {tag, " R4/R5/R6 read count"}, rd_total - start, enrd);
    if (enrd >= 1) chk(rd_log[start % 16] == ea1, {tag, " R3 directory address"}, rd_log[start % 16], ea1);
    if (enrd == 2) chk(rd_log[(start + 1) % 16] == ea2, {tag, " R3 leaf address"}, rd_log[(start + 1) % 16], ea2);
    @(negedge clk);
    chk(!rsp_valid && req_ready, {tag, " R9 one-cycle response"}, {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nbad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    root_cur = '0; len_cur = '0;
    hold_err = 0; nchk = 0; nbad = 0;
    // page 0 and page 3: directories, pages 1 and 2: leaves
    for (int i = 0; i < 1024; i++) begin
      mem_w[i]        = (i % 5 == 3) ? 32'h0 : {20'(1 + i % 2), 10'($urandom), 1'b0, 1'b1};
      mem_w[3072 + i] = (i % 7 == 0) ? 32'h0 : {20'(2 - i % 2), 10'($urandom), 2'b11};
      mem_w[1024 + i] = {20'($urandom), 10'($urandom), 1'($urandom), 1'($urandom % 6 != 0)};
      mem_w[2048 + i] = {20'($urandom), 10'($urandom), 1'($urandom), 1'($urandom % 6 != 0)};
    end
    mem_w[1024 + 7] = {20'hABCDE, 10'h3FF, 1'b1, 1'b0};  // absent leaf
    mem_w[1024 + 8] = {20'h12345, 10'h155, 1'b0, 1'b1};  // read-only leaf
    mem_w[1024 + 9] = {20'h0F0F0, 10'h0AA, 1'b1, 1'b1};  // writable leaf

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready && !rsp_valid && !mem_valid, "R1 reset outputs",
        {29'd0, req_ready, rsp_valid, mem_valid}, 32'd4);
    run_req(32'h0000_1234, 1'b0, "R1 len0 range");

    load_cfg(32'h0000_0000, 11'd600);
    run_req({10'd599, 10'd20, 12'h456}, 1'b0, "R4 last in range");
    run_req({10'd600, 10'd20, 12'h456}, 1'b0, "R4 first out of range");
    run_req({10'd1023, 10'd0, 12'h000}, 1'b1, "R4 top index");
    run_req({10'd3, 10'd5, 12'h111}, 1'b0, "R5 absent directory");
    run_req({10'd0, 10'd7, 12'habc}, 1'b0, "R6 absent leaf");
    run_req({10'd0, 10'd8, 12'hfed}, 1'b1, "R7 write read-only");
    run_req({10'd0, 10'd8, 12'hfed}, 1'b0, "R7 read read-only");
    run_req({10'd0, 10'd9, 12'h001}, 1'b1, "R7 write writable");

    load_cfg(32'h0000_3000, 11'd1024);
    run_req({10'd1023, 10'd33, 12'h777}, 1'b0, "R10 new root top");
    run_req({10'd0, 10'd33, 12'h777}, 1'b0, "R10 new root absent");

    // R10 same-cycle load uses old values
    @(negedge clk);
    req_va = {10'd10, 10'd4, 12'h0};
    req_write = 1'b0; req_valid = 1'b1; cfg_load = 1'b1; cfg_root = 32'h0; cfg_len = 11'd0;
    @(negedge clk);
    req_valid = 1'b0; cfg_load = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_status == 2'd0 || rsp_status == 2'd2, "R10 same-cycle load uses old length",
        {30'd0, rsp_status}, 32'd0);
    root_cur = 32'h0; len_cur = 11'd0;
    @(negedge clk);
    run_req({10'd10, 10'd4, 12'h0}, 1'b0, "R10 later request sees new length");

    for (int n = 0; n < 400; n++) begin
      if (n % 100 == 0)
        load_cfg((n % 200 == 0) ? 32'h0 : 32'h3000, 11'(($urandom % 1024) + 1));
      begin
        int i1;
        i1 = $urandom % (int'(len_cur) + 8);
        if (i1 > 1023) i1 = 1023;
        run_req({10'(i1), 22'($urandom)}, 1'($urandom), "random");
      end
    end

    chk(hold_err == 0, "R11 request held while not ready", hold_err, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule